// File: doc/BRIEF.md
# Window Watchdog with Sleep Window

This block watches a microcontroller through a single trigger line. Time is divided into monitoring cycles. Each cycle opens with a closed interval and then an open interval. A trigger rising edge counts only if it lands in the open interval, and it then starts the next cycle. A trigger that arrives too soon, or no trigger before the open interval runs out, makes the block drive a reset pulse to the microcontroller. After each reset pulse a switch-over interval follows, and any trigger during it is ignored.

A safety-enable output can turn on external actuators. It rises only after three accepted triggers in a row. Any reset pulse drops it in the same cycle. A mode input picks between two window lengths. The short window is for normal running. The long window lets a sleeping microcontroller wake at intervals. While the long window is in force, safety-enable stays low and six active-high wake inputs are watched. Any one of them cuts the sleep short with a reset pulse. A time-select input picks one of two open-interval lengths for the long window. All interval lengths are parameters counted in clock cycles, and all asynchronous inputs pass through two-flop synchronizers.

Top module: `wdog_window`

## Requirements
- R1: While `rst` is high, and afterwards until the T_PWRUP-th rising clock edge after `rst` falls, `mcu_rst` is 1 and `safe_en` is 0.
- R2: After any reset pulse ends, a switch-over interval of T_SW cycles follows. A trigger edge inside it causes no reset and does not move the cycle timing.
- R3: A trigger edge acted on in the open interval (cycle offsets T_SC+1 to T_SC+T_SO inclusive, counted from the cycle start edge) is accepted without a reset and starts a new cycle. The design acts on an input edge three clock edges after it is applied.
- R4: Every reset pulse lasts exactly T_RST cycles. When no trigger comes, the pulse starts at offset T_SC+T_SO in short mode.
- R5: A trigger edge in the closed interval (offsets 1 to T_SC) starts a reset pulse and clears the count of accepted triggers.
- R6: `safe_en` is 1 exactly when the last three cycles were short-mode cycles each ended by an accepted trigger. It is 0 in the cycle a reset pulse starts.
- R7: If `mode_in` is 1 when a cycle starts, that cycle uses the long closed interval T_LC. `safe_en` is 0 throughout it, and an accepted trigger does not add to the count.
- R8: In a long cycle, `tsel_in` = 0 gives an open interval of T_LOA cycles and `tsel_in` = 1 gives T_LOB cycles. The value is taken when the open interval begins.
- R9: A high level on any bit of `wake_in` during a long cycle starts a reset pulse. In a short cycle it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Trigger from the supervised controller (asynchronous) |
| mode_in | input | 1 | 1 selects the long window for the next cycle |
| tsel_in | input | 1 | Picks the long open-interval length |
| wake_in | input | N_WAKE | Active-high wake requests, ORed |
| mcu_rst | output | 1 | Reset to the controller, active high |
| safe_en | output | 1 | Safety enable after three good triggers |

## Verification
The hardest state to reach is a long cycle with its open interval under the second time-select length. Reaching it takes a mode change timed before a cycle start, a time-select change timed before the open interval, and a wait of more than a hundred cycles, all without a stray edge. The bench tracks the cycle start edge from each accepted trigger and each reset pulse end. It then places every trigger, mode, time-select and wake change at a computed offset, including exact edges of the closed and open intervals. Random trigger offsets in short mode then exercise the three-in-a-row count against a bench model.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_SWITCH = 2'd1,
        ST_CLOSED = 2'd2,
        ST_OPEN   = 2'd3
    } wdw_st_t;

    // synchronized, decoded inputs
    typedef struct packed {
        logic trig;   // one-cycle rising-edge strobe
        logic mode;
        logic tsel;
        logic wake;   // OR of all wake lines
    } wdw_in_t;

    // per-cycle decisions of the sequencer
    typedef struct packed {
        logic good;        // accepted trigger
        logic rst_start;   // reset pulse begins
        logic cyc_start;   // new monitoring cycle begins
        logic long_start;  // new cycle is a long one
    } wdw_evt_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wdw_sync.sv
module wdw_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/wdw_fsm.sv
module wdw_fsm
    import wdw_pkg::*;
#(
    parameter int T_PWRUP = 20,
    parameter int T_RST   = 8,
    parameter int T_SW    = 10,
    parameter int T_SC    = 16,
    parameter int T_SO    = 16,
    parameter int T_LC    = 64,
    parameter int T_LOA   = 48,
    parameter int T_LOB   = 96,
    parameter int CW      = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  wdw_in_t  in_s,
    output wdw_st_t  st,
    output logic     long_q,
    output wdw_evt_t evt
);
    logic [CW-1:0] cnt;
    logic          wk;
    logic [CW-1:0] open_len;

    assign wk = long_q && in_s.wake;

    always_comb begin
        if (!long_q)        open_len = CW'(T_SO - 1);
        else if (in_s.tsel) open_len = CW'(T_LOB - 1);
        else                open_len = CW'(T_LOA - 1);
    end

    always_comb begin
        evt = '0;
        case (st)
            ST_SWITCH: evt.cyc_start = (cnt == '0);
            ST_CLOSED: evt.rst_start = in_s.trig || wk;
            ST_OPEN: begin
                evt.good      = in_s.trig && !wk;
                evt.rst_start = wk || (!in_s.trig && cnt == '0);
                evt.cyc_start = evt.good;
            end
            default: ;
        endcase
        evt.long_start = evt.cyc_start && in_s.mode;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_HOLD;
            cnt    <= CW'(T_PWRUP - 1);
            long_q <= 1'b0;
        end else if (evt.rst_start) begin
            st     <= ST_HOLD;
            cnt    <= CW'(T_RST - 1);
            long_q <= 1'b0;
        end else if (evt.cyc_start) begin
            st     <= ST_CLOSED;
            long_q <= in_s.mode;
            cnt    <= in_s.mode ? CW'(T_LC - 1) : CW'(T_SC - 1);
        end else if (cnt == '0) begin
            case (st)
                ST_HOLD: begin
                    st  <= ST_SWITCH;
                    cnt <= CW'(T_SW - 1);
                end
                ST_CLOSED: begin
                    st  <= ST_OPEN;
                    cnt <= open_len;
                end
                default: ;
            endcase
        end else begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/wdw_qual.sv
module wdw_qual
    import wdw_pkg::*;
#(
    parameter int N_GOOD = 3,
    parameter int GW     = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  wdw_evt_t      evt,
    input  logic          long_q,
    output logic [GW-1:0] good_cnt,
    output logic          safe_en
);
    always_ff @(posedge clk) begin
        if (rst || evt.rst_start || evt.long_start)
            good_cnt <= '0;
        else if (evt.good && !long_q && good_cnt != GW'(N_GOOD))
            good_cnt <= good_cnt + 1'b1;
    end

    assign safe_en = (good_cnt == GW'(N_GOOD));
endmodule

// File: rtl/wdog_window.sv
module wdog_window
    import wdw_pkg::*;
#(
    parameter int T_PWRUP = 20,
    parameter int T_RST   = 8,
    parameter int T_SW    = 10,
    parameter int T_SC    = 16,
    parameter int T_SO    = 16,
    parameter int T_LC    = 64,
    parameter int T_LOA   = 48,
    parameter int T_LOB   = 96,
    parameter int N_WAKE  = 6,
    parameter int N_GOOD  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_in,
    input  logic              mode_in,
    input  logic              tsel_in,
    input  logic [N_WAKE-1:0] wake_in,
    output logic              mcu_rst,
    output logic              safe_en
);
    localparam int LMAX = max2(max2(max2(T_PWRUP, T_RST), max2(T_SW, T_SC)),
                               max2(max2(T_SO, T_LC), max2(T_LOA, T_LOB)));
    localparam int CW   = $clog2(LMAX + 1);
    localparam int GW   = $clog2(N_GOOD + 1);
    localparam int SW   = N_WAKE + 3;

    logic [SW-1:0] sync_q;
    logic          trig_d;
    logic          trig_e;
    logic          wake_e;
    wdw_in_t       in_s;
    wdw_st_t       st;
    logic          long_q;
    wdw_evt_t      evt;
    logic [GW-1:0] good_cnt;

    wdw_sync #(.W(SW)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({wake_in, tsel_in, mode_in, trig_in}),
        .q   (sync_q)
    );

    always_ff @(posedge clk) begin
        if (rst) trig_d <= 1'b0;
        else     trig_d <= sync_q[0];
    end

    assign trig_e = sync_q[0] & ~trig_d;
    assign wake_e = |sync_q[SW-1:3];
    assign in_s   = '{trig: trig_e, mode: sync_q[1], tsel: sync_q[2], wake: wake_e};

    wdw_fsm #(
        .T_PWRUP(T_PWRUP), .T_RST(T_RST), .T_SW(T_SW), .T_SC(T_SC),
        .T_SO(T_SO), .T_LC(T_LC), .T_LOA(T_LOA), .T_LOB(T_LOB), .CW(CW)
    ) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .in_s   (in_s),
        .st     (st),
        .long_q (long_q),
        .evt    (evt)
    );

    wdw_qual #(.N_GOOD(N_GOOD), .GW(GW)) u_qual (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .long_q   (long_q),
        .good_cnt (good_cnt),
        .safe_en  (safe_en)
    );

    assign mcu_rst = (st == ST_HOLD);
endmodule

// File: rtl/wdog_window_chk.sv
module wdog_window_chk
    import wdw_pkg::*;
#(
    parameter int T_RST  = 8,
    parameter int N_GOOD = 3,
    parameter int GW     = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          mcu_rst,
    input logic          safe_en,
    input logic          trig_e,
    input logic          wake_e,
    input logic          long_q,
    input wdw_st_t       st,
    input logic [GW-1:0] good_cnt
);
    int run_q;

    always_ff @(posedge clk) begin
        if (rst)          run_q <= 0;
        else if (mcu_rst) run_q <= run_q + 1;
        else              run_q <= 0;
    end

    p_rst_len_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(mcu_rst) |-> run_q >= T_RST);

    p_en_in_rst_r6: assert property (@(posedge clk) disable iff (rst)
        mcu_rst |-> !safe_en);

    p_en_rise_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(safe_en) |-> $past(trig_e));

    p_cnt_max_r6: assert property (@(posedge clk) disable iff (rst)
        good_cnt <= GW'(N_GOOD));

    p_en_long_r7: assert property (@(posedge clk) disable iff (rst)
        long_q |-> !safe_en);

    p_early_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CLOSED && trig_e) |=> (mcu_rst && good_cnt == '0));

    p_ignore_r2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SWITCH && trig_e) |=> !mcu_rst);

    p_wake_r9: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_CLOSED || st == ST_OPEN) && long_q && wake_e) |=> mcu_rst);
endmodule

bind wdog_window wdog_window_chk #(.T_RST(T_RST), .N_GOOD(N_GOOD), .GW(GW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mcu_rst  (mcu_rst),
    .safe_en  (safe_en),
    .trig_e   (trig_e),
    .wake_e   (wake_e),
    .long_q   (long_q),
    .st       (st),
    .good_cnt (good_cnt)
);

// File: tb/wdog_window_bench.sv
`timescale 1ns/1ps
module wdog_window_bench;
    localparam int T_PWRUP = 20, T_RST = 8, T_SW = 10, T_SC = 16, T_SO = 16;
    localparam int T_LC = 64, T_LOA = 48, T_LOB = 96, N_WAKE = 6;
    localparam int K_GOOD = 0, K_FAULT = 1, K_IGN = 2;

    logic clk = 1'b0, rst = 1'b1, trig_in = 1'b0, mode_in = 1'b0, tsel_in = 1'b0;
    logic [N_WAKE-1:0] wake_in = '0;
    logic mcu_rst, safe_en;

    int  cyc = 0, nchk = 0, nerr = 0;
    int  S = 0, gexp = 0;
    bit  mode_now = 0, cur_long = 0, done = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdog_window #(.T_PWRUP(T_PWRUP), .T_RST(T_RST), .T_SW(T_SW), .T_SC(T_SC),
        .T_SO(T_SO), .T_LC(T_LC), .T_LOA(T_LOA), .T_LOB(T_LOB), .N_WAKE(N_WAKE),
        .N_GOOD(3)) u_wdog_window (
        .clk(clk), .rst(rst), .trig_in(trig_in), .mode_in(mode_in),
        .tsel_in(tsel_in), .wake_in(wake_in), .mcu_rst(mcu_rst), .safe_en(safe_en));

    function automatic bit short_ok(input int d);
        return (d > T_SC) && (d <= T_SC + T_SO);
    endfunction

    function automatic int next_cnt(input int c, input bit ok, input bit lng_now, input bit lng_next);
        if (!ok || lng_next) return 0;
        if (lng_now) return c;
        return (c < 3) ? c + 1 : 3;
    endfunction

    task automatic chk(input int act, input int exp, input string tag);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic to_neg(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // called at the negedge where mcu_rst is first seen high
    task automatic meas_pulse(input int len, input string tag);
        int n = 0;
        do begin @(negedge clk); n++; end while (mcu_rst && n < 1000);
        chk(n, len, tag);
        S = cyc + T_SW;
        gexp = 0;
        cur_long = mode_now;
    endtask

    task automatic do_trig(input int d, input int kind, input string tag);
        int k = S + d - 3;
        to_neg(k);   trig_in = 1'b1;
        to_neg(k + 2); trig_in = 1'b0;
        to_neg(k + 3);
        if (kind == K_GOOD) begin
            chk(int'(mcu_rst), 0, {tag, " accepted"});
            gexp = next_cnt(gexp, 1'b1, cur_long, mode_now);
            chk(int'(safe_en), int'(gexp == 3), {tag, " R6 enable"});
            S = k + 3;
            cur_long = mode_now;
        end else if (kind == K_FAULT) begin
            chk(int'(mcu_rst), 1, {tag, " R5 reset"});
            chk(int'(safe_en), 0, {tag, " R6 drop"});
            meas_pulse(T_RST, {tag, " R4 width"});
        end else begin
            to_neg(k + 4);
            chk(int'(mcu_rst), 0, {tag, " R2 ignored"});
            chk(int'(safe_en), int'(gexp == 3), {tag, " R2 enable"});
        end
    endtask

    task automatic do_timeout(input int len, input string tag);
        to_neg(S + len - 1);
        chk(int'(mcu_rst), 0, {tag, " before"});
        to_neg(S + len);
        chk(int'(mcu_rst), 1, {tag, " at expiry"});
        chk(int'(safe_en), 0, {tag, " R6 drop"});
        meas_pulse(T_RST, {tag, " R4 width"});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5020));
        repeat (5) @(negedge clk);
        chk(int'(mcu_rst), 1, "R1 in reset");
        chk(int'(safe_en), 0, "R1 enable in reset");
        rst = 1'b0;
        meas_pulse(T_PWRUP, "R1 power-up width");
        chk(int'(safe_en), 0, "R1 enable after power-up");

        // R2: trigger inside switch-over
        do_trig(-4, K_IGN, "R2");
        // R3 boundary: first open offset, last open offset
        do_trig(T_SC + 1, K_GOOD, "R3 first open");
        do_trig(T_SC + T_SO, K_GOOD, "R3 last open");
        do_trig(24, K_GOOD, "R3 mid");
        chk(int'(safe_en), 1, "R6 three in a row");
        // R5 boundary: last closed offset
        do_trig(T_SC, K_FAULT, "R5 last closed");
        do_trig(24, K_GOOD, "R3 after fault");
        do_trig(24, K_GOOD, "R3 second");
        chk(int'(safe_en), 0, "R6 two only");
        do_timeout(T_SC + T_SO, "R4 missing trigger");

        // R7: build enable, then enter long window
        do_trig(24, K_GOOD, "R3 a"); do_trig(24, K_GOOD, "R3 b"); do_trig(24, K_GOOD, "R3 c");
        chk(int'(safe_en), 1, "R6 rebuilt");
        mode_in = 1'b1; mode_now = 1'b1;
        do_trig(24, K_GOOD, "R7 enter long");
        do_trig(T_SC + T_SO, K_FAULT, "R7 long closed");
        do_trig(T_LC + 10, K_GOOD, "R7 long open");
        chk(int'(safe_en), 0, "R7 enable low");
        // R8: both long open lengths
        do_timeout(T_LC + T_LOA, "R8 tsel0");
        tsel_in = 1'b1;
        to_neg(S + T_LC + T_LOA + 2);
        chk(int'(mcu_rst), 0, "R8 tsel1 past short length");
        do_timeout(T_LC + T_LOB, "R8 tsel1");
        tsel_in = 1'b0;

        // R9: wake during long cycle
        to_neg(S + 10); mode_in = 1'b0; mode_now = 1'b0;
        to_neg(S + 20); wake_in = 6'b001000;
        to_neg(S + 22); chk(int'(mcu_rst), 0, "R9 wake latency");
        to_neg(S + 23); chk(int'(mcu_rst), 1, "R9 wake reset");
        wake_in = '0;
        meas_pulse(T_RST, "R9 R4 width");
        // R9: wake in short cycle has no effect
        to_neg(S + 5);  wake_in = 6'b100000;
        to_neg(S + 12); wake_in = '0;
        to_neg(S + 14); chk(int'(mcu_rst), 0, "R9 short wake ignored");
        do_trig(24, K_GOOD, "R9 cycle intact");

        // random short-mode offsets
        for (int i = 0; i < 60; i++) begin
            if ($urandom_range(0, 7) == 0) begin
                do_timeout(T_SC + T_SO, "R4 rnd");
            end else begin
                int d;
                d = int'($urandom_range(4, 32));
                do_trig(d, short_ok(d) ? K_GOOD : K_FAULT, "R6 rnd");
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule